// File: doc/BRIEF.md
# Narrow Pulse Clock-Domain Synchronizer

This block carries single-bit events from a source with no timing relation to the receiving clock into that clock's domain. An event arrives as a rising edge on `pulse_in`. The pulse may be much shorter than one receiving-clock period, and it may come at any phase. The rising edge sets an edge-triggered capture flop whose data input is tied high, so the event is held even after the pulse is gone. A chain of receiving-domain flops then resynchronizes the held level, and the chain output is `pulse_out`.

When `pulse_out` goes high, it asynchronously clears the capture flop. The block is then ready for the next event once the cleared level has passed through the chain. Each captured event produces one `pulse_out` pulse of fixed width. Events that arrive too close together are merged into one pulse, or are dropped. The active-low reset asserts at once and is released in step with the receiving clock.

Top module: `narrow_pulse_sync`

## Requirements
- R1: While `rst_n` is low, `pulse_out` is 0 and rising edges on `pulse_in` are not remembered. Asserting `rst_n` while `pulse_out` is high forces `pulse_out` to 0 at once, without waiting for a clock edge.
- R2: A single rising edge on `pulse_in` produces exactly one `pulse_out` pulse. This holds whether the input pulse lasts 1 ns (shorter than the 8 ns period) or several clock periods, and at any phase relative to `clk`.
- R3: Let the input edge arrive between receiving edges k and k+1. Then `pulse_out` is 0 after edge k+1 and 1 after edge k+2.
- R4: Each `pulse_out` pulse is high for exactly two `clk` cycles, after edges k+2 and k+3, and is low after edge k+4.
- R5: While `pulse_out` is high, the capture flop is held clear, so input edges that arrive in that window produce no further output.
- R6: Input edges that arrive after the capture flop is set and before `pulse_out` rises merge with the first edge into a single output pulse.
- R7: An input edge that arrives after `pulse_out` has returned low is captured as a new event: `pulse_out` rises again on the second `clk` edge after it.
- R8: Reset release is synchronous. The internal reset stays asserted until the second `clk` rising edge after `rst_n` rises, so an input edge that arrives before that second edge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiving-domain clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| pulse_in | input | 1 | Asynchronous event input; only its rising edge matters |
| pulse_out | output | 1 | Synchronized event pulse, two `clk` cycles wide |

## Verification
The bench fires pulses of 1 to 2 ns at random phases within a clock period, and checks the exact edge on which the output rises and falls. A chain with an extra or missing stage would move the rising edge, and a wrong feedback path would stretch the pulse or end it early. Three further cases target the capture flop:
- Edges that land during the output pulse: a design whose clear did not dominate the capture edge would emit a second pulse for them.
- Edges stacked before the output rises: these must merge into one pulse.
- An edge just after the output falls: a design that held the clear too long would lose it.

Reset is checked both during activity and at release. A design that released its reset asynchronously would capture an edge that arrives within two clock edges after release.

// File: rtl/nps_pkg.sv
`timescale 1ns/1ps
package nps_pkg;
  // Number of receiving-domain flops between capture and output.
  localparam int unsigned NPS_SYNC_STAGES_DEF = 2;
  // Number of flops in the reset release synchronizer.
  localparam int unsigned NPS_RST_STAGES_DEF  = 2;
endpackage

// File: rtl/nps_reset_sync.sv
`timescale 1ns/1ps
module nps_reset_sync #(
  parameter int unsigned STAGES = nps_pkg::NPS_RST_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  // Next state: shift a constant one in from the bottom.
  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];

  // R8: the first clock edge that sees the external reset released still sees the internal one held.
  p_release_lags_r8: assert property (@(posedge clk) $rose(rst_n) |-> !rst_sync_n)
    else $error("internal reset released together with rst_n");
endmodule

// File: rtl/nps_edge_capture.sv
`timescale 1ns/1ps
module nps_edge_capture (
  input  logic edge_in,
  input  logic clear,
  output logic held
);
  // Data tied high: a rising edge on edge_in records an event; clear wins.
  always_ff @(posedge edge_in or posedge clear) begin
    if (clear) held <= 1'b0;
    else       held <= 1'b1;
  end
endmodule

// File: rtl/nps_resync_chain.sv
`timescale 1ns/1ps
module nps_resync_chain #(
  parameter int unsigned STAGES = nps_pkg::NPS_SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic first_q,
  output logic dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] stage_q;
  logic [LAST:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stage_d = din;
    end else begin : g_multi
      always_comb stage_d = {stage_q[LAST-1:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign first_q = stage_q[0];
  assign dout    = stage_q[LAST];
endmodule

// File: rtl/narrow_pulse_sync.sv
`timescale 1ns/1ps
module narrow_pulse_sync #(
  parameter int unsigned SYNC_STAGES = nps_pkg::NPS_SYNC_STAGES_DEF,
  parameter int unsigned RST_STAGES  = nps_pkg::NPS_RST_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic pulse_out
);
  logic rst_int_n;
  logic cap_clear;
  logic cap_held;
  logic stage1;
  logic out_q;

  nps_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // The capture flop is cleared by reset or by its own synchronized result.
  assign cap_clear = ~rst_int_n | out_q;

  nps_edge_capture u_cap (
    .edge_in (pulse_in),
    .clear   (cap_clear),
    .held    (cap_held)
  );

  nps_resync_chain #(.STAGES(SYNC_STAGES)) u_chain (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .din     (cap_held),
    .first_q (stage1),
    .dout    (out_q)
  );

  assign pulse_out = out_q;

  // R1: output and capture are clear while internal reset is held.
  p_quiet_in_reset_r1: assert property (@(posedge clk) !rst_int_n |-> (!out_q && !cap_held))
    else $error("activity during reset");

  // R2: first stage rises only after the capture flop held an event.
  p_stage_from_capture_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(stage1) |-> $past(cap_held))
    else $error("first stage rose without a captured event");

  // R4: a rising output stays high for the next cycle.
  p_width_min_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(out_q) |=> out_q)
    else $error("output pulse shorter than two cycles");

  // R4: the output is never high for a third cycle.
  p_width_max_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_q && $past(out_q)) |=> !out_q)
    else $error("output pulse longer than two cycles");

  // R5: the capture flop is empty whenever the output is high.
  p_clear_while_high_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_q |-> !cap_held)
    else $error("capture flop set while output high");
endmodule

// File: tb/narrow_pulse_sync_bench.sv
`timescale 1ns/1ps
module narrow_pulse_sync_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic pulse_in;
  logic pulse_out;
  int   n_chk  = 0;
  int   n_fail = 0;
  int   rises  = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  narrow_pulse_sync u_narrow_pulse_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_in  (pulse_in),
    .pulse_out (pulse_out)
  );

  always @(posedge pulse_out) rises++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Sample 2 ns after the next rising edge.
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic blip(input int width);
    pulse_in = 1'b1;
    #(width);
    pulse_in = 1'b0;
  endtask

  // Pulse inside the period after edge k; returns before edge k+1.
  task automatic fire(input int phase, input int width);
    @(posedge clk);
    #(phase);
    blip(width);
  endtask

  // Expected output after edges k+1..k+4: 0,1,1,0 (R3, R4).
  task automatic expect_shape(input string tag);
    step(); chk(pulse_out == 1'b0, {tag, " R3 k+1"}, pulse_out, 0);
    step(); chk(pulse_out == 1'b1, {tag, " R3 k+2"}, pulse_out, 1);
    step(); chk(pulse_out == 1'b1, {tag, " R4 k+3"}, pulse_out, 1);
    step(); chk(pulse_out == 1'b0, {tag, " R4 k+4"}, pulse_out, 0);
  endtask

  task automatic t_reset();
    int r0;
    rst_n = 1'b1; pulse_in = 1'b0;
    #1 rst_n = 1'b0;
    step(); chk(pulse_out == 1'b0, "R1 reset state", pulse_out, 0);
    r0 = rises;
    #1 blip(1);
    repeat (4) step();
    chk(rises == r0, "R1 edge in reset", rises - r0, 0);
    // R8: edge just after release but before the second clock edge.
    @(posedge clk); #2 rst_n = 1'b1;
    #1 blip(1);
    repeat (6) step();
    chk(rises == r0 && pulse_out == 1'b0, "R8 edge during release", rises - r0, 0);
  endtask

  task automatic t_random_narrow();
    for (int i = 0; i < 16; i++) begin
      int r0 = rises;
      fire(int'($urandom_range(1, 5)), int'($urandom_range(1, 2)));
      expect_shape("R2 narrow");
      repeat (2) step();
      chk(rises - r0 == 1, "R2 one output per edge", rises - r0, 1);
    end
  endtask

  task automatic t_wide();
    int r0 = rises;
    @(posedge clk); #2 pulse_in = 1'b1;
    step(); chk(pulse_out == 1'b0, "R3 wide k+1", pulse_out, 0);
    step(); chk(pulse_out == 1'b1, "R3 wide k+2", pulse_out, 1);
    #18 pulse_in = 1'b0;
    repeat (5) step();
    chk(rises - r0 == 1, "R2 wide pulse single output", rises - r0, 1);
  endtask

  task automatic t_merge();
    int r0 = rises;
    @(posedge clk); #1 blip(1); #2 blip(1);
    step(); chk(pulse_out == 1'b0, "R6 merge k+1", pulse_out, 0);
    #1 blip(1);  // capture still set
    step(); chk(pulse_out == 1'b1, "R6 merge k+2", pulse_out, 1);
    step(); chk(pulse_out == 1'b1, "R6 merge k+3", pulse_out, 1);
    step(); chk(pulse_out == 1'b0, "R6 merge k+4", pulse_out, 0);
    repeat (4) step();
    chk(rises - r0 == 1, "R6 merged count", rises - r0, 1);
  endtask

  task automatic t_drop_while_high();
    int r0 = rises;
    fire(2, 1);
    step();
    step(); chk(pulse_out == 1'b1, "R5 high k+2", pulse_out, 1);
    #1 blip(1);
    step(); chk(pulse_out == 1'b1, "R5 high k+3", pulse_out, 1);
    #1 blip(1);
    step(); chk(pulse_out == 1'b0, "R5 low k+4", pulse_out, 0);
    repeat (5) step();
    chk(rises - r0 == 1 && pulse_out == 1'b0, "R5 edges while high dropped", rises - r0, 1);
  endtask

  task automatic t_separate();
    int r0 = rises;
    fire(3, 1);
    expect_shape("R7 first");
    #1 blip(1);
    step(); chk(pulse_out == 1'b0, "R7 second k+1", pulse_out, 0);
    step(); chk(pulse_out == 1'b1, "R7 second k+2", pulse_out, 1);
    repeat (4) step();
    chk(rises - r0 == 2, "R7 two events", rises - r0, 2);
  endtask

  task automatic t_reset_mid();
    fire(1, 1);
    step(); step();
    chk(pulse_out == 1'b1, "R1 pre-reset high", pulse_out, 1);
    rst_n = 1'b0;
    #1 chk(pulse_out == 1'b0, "R1 async clear", pulse_out, 0);
    repeat (3) step();
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (3) step();
    fire(2, 1);
    expect_shape("R1 after re-release");
  endtask

  initial begin
    t_reset();
    t_random_narrow();
    t_wide();
    t_merge();
    t_drop_while_high();
    t_separate();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule